// File: doc/BRIEF.md
# Local Interrupt Timer

This block is a per-core interrupt timer controlled through a small register port. Software programs a timer entry that holds an 8-bit interrupt vector, a mask bit and a mode field. It also sets a clock divider and then starts a countdown by writing an initial count. A read-only register shows the current count.

In one-shot mode the counter raises a single interrupt when it reaches zero. In periodic mode it reloads from the initial count each time it expires. In deadline mode the countdown is idle. Instead, a free-running time counter is compared against a deadline register, and the interrupt fires as soon as the time counter is at or past the deadline.

Every expiry produces a one-cycle request that carries the programmed vector. Switching between one-shot and periodic leaves the running count where it is. Prioritisation, acknowledgement and delivery of the interrupt are handled elsewhere.

Top module: `lit_timer`

## Requirements
- R1: After reset, register 0 (timer entry) reads 0x0001_0000 (masked, one-shot, vector 0), and registers 1 (divider), 2 (initial count), 3 (current count) and 4 (deadline) read zero; register 5 is the free-running time counter, which advances by one every clock.
- R2: The timer entry fields are vector in bits 7:0, mask in bit 16 and mode in bits 18:17, where 00 is one-shot, 01 is periodic and 10 is deadline (11 behaves as one-shot).
- R3: A write to register 2 loads the current count on the same edge and starts the countdown. With divider value 0xB (divide by 1), an initial count of N produces the interrupt request in the Nth cycle after the write.
- R4: Divider bits {3,1,0} = v below 7 give a divide ratio of 2^(v+1), and v = 7 gives divide by 1. A write to register 2 restarts the prescaler, so with v = 0 an initial count of N expires 2N cycles after the write.
- R5: In one-shot mode the count reaches zero, exactly one request is raised, and the count then stays at zero.
- R6: In periodic mode the count reloads from register 2 on each expiry, giving one request every N cycles at divide by 1.
- R7: Writing the timer entry to change between one-shot and periodic neither reloads nor clears the current count, and register 2 keeps its value.
- R8: A one-shot count that has already reached zero stays at zero and raises nothing after a switch to periodic mode.
- R9: In deadline mode, a deadline at or below the time counter fires in the cycle after it is written, and register 4 then reads zero.
- R10: A deadline in the future fires in the first cycle in which the time counter equals it.
- R11: Writing an initial count of zero stops the countdown, and no request follows.
- R12: The request `irq_valid` is a one-cycle pulse with `irq_vector` equal to the programmed vector. The mask bit suppresses the pulse, but the countdown still runs to zero.
- R13: If a write to register 2 falls in the same cycle as the final decrement, the load wins and no request is raised for the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register index for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The last decrement of a running count and a software write of a new initial count can land on the same clock edge. The bench provokes this by loading a count of 8 at divide by 1 and then timing a second write of 8 so that it is captured on exactly the edge where the count would go from 1 to 0. It then requires that no request appears on that edge and that the single request arrives 8 cycles after the second write. A mode write landing on a decrement edge is provoked in the same way, and the count read back must be one lower and not reloaded.

// File: rtl/lit_pkg.sv
package lit_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int VEC_W    = 8;
  localparam int MASK_BIT = 16;
  localparam int MODE_LSB = 17;
  localparam int DIV_W    = 4;

  typedef enum logic [1:0] {
    LIT_ONESHOT  = 2'b00,
    LIT_PERIODIC = 2'b01,
    LIT_DEADLINE = 2'b10,
    LIT_RSVD     = 2'b11
  } lit_mode_e;

  localparam logic [ADDR_W-1:0] A_ENTRY = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV   = 3'd1;
  localparam logic [ADDR_W-1:0] A_INIT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CUR   = 3'd3;
  localparam logic [ADDR_W-1:0] A_DLINE = 3'd4;
  localparam logic [ADDR_W-1:0] A_TIME  = 3'd5;
endpackage

// File: rtl/lit_prescaler.sv
module lit_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] ratio_sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q, pre_d, mask;
  logic [3:0]       shamt;

  always_comb begin
    shamt = {1'b0, ratio_sel} + 4'd1;
    if (ratio_sel == 3'b111) mask = '0;
    else                     mask = ~({PRE_W{1'b1}} << shamt);
    tick  = ((pre_q & mask) == mask);
    pre_d = restart ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/lit_countdown.sv
module lit_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             run,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             fire
);
  logic [CNT_W-1:0] cur_q, cur_d;
  logic             cur_en;

  always_comb begin
    cur_d  = cur_q;
    cur_en = 1'b0;
    fire   = 1'b0;
    if (load) begin
      cur_d  = load_val;
      cur_en = 1'b1;
    end else if (run && tick && (cur_q != '0)) begin
      cur_en = 1'b1;
      if (cur_q == CNT_W'(1)) begin
        fire  = 1'b1;
        cur_d = periodic ? reload_val : '0;
      end else begin
        cur_d = cur_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  assign cur = cur_q;
endmodule

// File: rtl/lit_deadline.sv
module lit_deadline #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [TIME_W-1:0] wval,
  input  logic              armed,
  output logic [TIME_W-1:0] dline,
  output logic [TIME_W-1:0] now,
  output logic              fire
);
  logic [TIME_W-1:0] dl_q, dl_d, now_q, now_d;
  logic              dl_en;

  always_comb begin
    now_d = now_q + 1'b1;
    fire  = armed && !wr && (dl_q != '0) && (now_q >= dl_q);
    dl_en = wr || fire;
    dl_d  = wr ? wval : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '0;
      dl_q  <= '0;
    end else begin
      now_q <= now_d;
      if (dl_en) dl_q <= dl_d;
    end
  end

  assign dline = dl_q;
  assign now   = now_q;
endmodule

// File: rtl/lit_timer.sv
module lit_timer
  import lit_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32,
  parameter int PRE_W  = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_valid,
  output logic [7:0]  irq_vector
);
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             mask_q, mask_d;
  lit_mode_e        mode_q, mode_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] init_q, init_d;
  logic             entry_wr, div_wr, init_wr, dl_wr;
  logic             tick, cnt_fire, dl_fire;
  logic [CNT_W-1:0]  cur_cnt;
  logic [TIME_W-1:0] dl_val, time_val;
  logic             irq_q, irq_d;
  logic [VEC_W-1:0] irqv_q, irqv_d;

  // Write decode and next-state of the software-visible registers
  always_comb begin
    entry_wr = wr_en && (addr == A_ENTRY);
    div_wr   = wr_en && (addr == A_DIV);
    init_wr  = wr_en && (addr == A_INIT);
    dl_wr    = wr_en && (addr == A_DLINE);
    vec_d    = entry_wr ? wdata[VEC_W-1:0] : vec_q;
    mask_d   = entry_wr ? wdata[MASK_BIT] : mask_q;
    mode_d   = entry_wr ? lit_mode_e'(wdata[MODE_LSB+1:MODE_LSB]) : mode_q;
    div_d    = div_wr   ? wdata[DIV_W-1:0] : div_q;
    init_d   = init_wr  ? wdata[CNT_W-1:0] : init_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      mask_q <= 1'b1;
      mode_q <= LIT_ONESHOT;
      div_q  <= '0;
      init_q <= '0;
    end else begin
      if (entry_wr) begin
        vec_q  <= vec_d;
        mask_q <= mask_d;
        mode_q <= mode_d;
      end
      if (div_wr)  div_q  <= div_d;
      if (init_wr) init_q <= init_d;
    end
  end

  lit_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (init_wr),
    .ratio_sel ({div_q[3], div_q[1:0]}),
    .tick      (tick)
  );

  lit_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (init_wr),
    .load_val   (wdata[CNT_W-1:0]),
    .reload_val (init_q),
    .tick       (tick),
    .run        (mode_q != LIT_DEADLINE),
    .periodic   (mode_q == LIT_PERIODIC),
    .cur        (cur_cnt),
    .fire       (cnt_fire)
  );

  lit_deadline #(.TIME_W(TIME_W)) u_dl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (dl_wr),
    .wval  (wdata[TIME_W-1:0]),
    .armed (mode_q == LIT_DEADLINE),
    .dline (dl_val),
    .now   (time_val),
    .fire  (dl_fire)
  );

  // Request pulse: registered, gated by the mask
  always_comb begin
    irq_d  = (cnt_fire || dl_fire) && !mask_q;
    irqv_d = irq_d ? vec_q : irqv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      irqv_q <= '0;
    end else begin
      irq_q <= irq_d;
      if (irq_d) irqv_q <= irqv_d;
    end
  end

  assign irq_valid  = irq_q;
  assign irq_vector = irqv_q;

  always_comb begin
    case (addr)
      A_ENTRY: rdata = {13'b0, mode_q, mask_q, 8'b0, vec_q};
      A_DIV:   rdata = DATA_W'(div_q);
      A_INIT:  rdata = DATA_W'(init_q);
      A_CUR:   rdata = DATA_W'(cur_cnt);
      A_DLINE: rdata = DATA_W'(dl_val);
      A_TIME:  rdata = DATA_W'(time_val);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/lit_timer_chk.sv
module lit_timer_chk
  import lit_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_valid,
  input logic [7:0]        irq_vector,
  input logic              mask,
  input logic [7:0]        vec,
  input logic [1:0]        mode,
  input logic [CNT_W-1:0]  cur,
  input logic              load,
  input logic [CNT_W-1:0]  load_val,
  input logic [TIME_W-1:0] dl,
  input logic              dl_fire
);
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur == $past(load_val));

  // R5 and R8: a zero count in non-periodic state stays zero whatever the next mode
  p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LIT_ONESHOT && cur == '0 && !load) |=> cur == '0);

  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cur > CNT_W'(1)) |=> (cur == $past(cur) || cur == $past(cur) - 1'b1));

  p_dl_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dl_fire |=> dl == '0);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == '0 && !load && mode != LIT_DEADLINE) |=> !irq_valid);

  p_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask));

  p_vector_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vector == $past(vec));
endmodule

bind lit_timer lit_timer_chk #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_valid  (irq_valid),
  .irq_vector (irq_vector),
  .mask       (mask_q),
  .vec        (vec_q),
  .mode       (mode_q),
  .cur        (cur_cnt),
  .load       (init_wr),
  .load_val   (wdata[CNT_W-1:0]),
  .dl         (dl_val),
  .dl_fire    (dl_fire)
);

// File: tb/lit_timer_bench.sv
module lit_timer_bench;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int n_tests;
  int n_fail;

  lit_timer u_lit_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [31:0] E_ONE = 32'h0000_0000;
  localparam logic [31:0] E_PER = 32'h0002_0000;
  localparam logic [31:0] E_DL  = 32'h0004_0000;
  localparam logic [31:0] E_MSK = 32'h0001_0000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // Watch n cycles: first pulse cycle index, pulse count, last vector
  task automatic watch(input int n, output int first, output int cnt, output logic [7:0] v);
    first = 0; cnt = 0; v = '0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (irq_valid) begin
        cnt++;
        v = irq_vector;
        if (first == 0) first = k;
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check("R1 entry reset", d, 32'h0001_0000);
    rd(3'd1, d); check("R1 divider reset", d, 0);
    rd(3'd2, d); check("R1 init reset", d, 0);
    rd(3'd3, d); check("R1 current reset", d, 0);
    rd(3'd4, d); check("R1 deadline reset", d, 0);
    check("R1 no request after reset", {31'b0, irq_valid}, 0);
  endtask

  task automatic t_oneshot();
    int f, c; logic [7:0] v; logic [31:0] d;
    wr(3'd0, E_ONE | 32'h41);
    rd(3'd0, d); check("R2 entry readback", d, 32'h41);
    wr(3'd1, 32'hB);
    wr(3'd2, 12);
    watch(40, f, c, v);
    check("R3 first request cycle", f, 12);
    check("R5 single request", c, 1);
    check("R12 vector", v, 8'h41);
    rd(3'd3, d); check("R5 count stays zero", d, 0);
  endtask

  task automatic t_div2();
    int f, c; logic [7:0] v;
    wr(3'd1, 32'h0);
    wr(3'd2, 6);
    watch(30, f, c, v);
    check("R4 divide-by-2 expiry cycle", f, 12);
    check("R4 single request", c, 1);
    wr(3'd1, 32'hB);
  endtask

  task automatic t_periodic();
    int f, c; logic [7:0] v; logic [31:0] d;
    wr(3'd0, E_PER | 32'h52);
    wr(3'd2, 10);
    watch(35, f, c, v);
    check("R6 first period", f, 10);
    check("R6 three periods", c, 3);
    check("R12 periodic vector", v, 8'h52);
    rd(3'd2, d); check("R6 init kept", d, 10);
    wr(3'd2, 0);
  endtask

  task automatic t_switch();
    int f, c; logic [7:0] v; logic [31:0] d;
    wr(3'd0, E_ONE | 32'h41);
    wr(3'd2, 40);
    repeat (9) @(negedge clk);
    rd(3'd3, d); check("R7 count before switch", d, 31);
    wr(3'd0, E_PER | 32'h41);
    rd(3'd3, d); check("R7 count not reloaded", d, 29);
    rd(3'd2, d); check("R7 init kept", d, 40);
    watch(29, f, c, v);
    check("R7 expiry continues from count", f, 29);
    rd(3'd3, d); check("R7 periodic reload after switch", d, 40);
    wr(3'd2, 0);
    wr(3'd0, E_ONE | 32'h41);
  endtask

  task automatic t_zero_switch();
    int f, c; logic [7:0] v; logic [31:0] d;
    wr(3'd2, 5);
    watch(10, f, c, v);
    check("R5 one request", c, 1);
    wr(3'd0, E_PER | 32'h41);
    watch(30, f, c, v);
    check("R8 no restart after switch", c, 0);
    rd(3'd3, d); check("R8 count stays zero", d, 0);
  endtask

  task automatic t_zero_init();
    int f, c; logic [7:0] v; logic [31:0] d;
    wr(3'd0, E_PER | 32'h41);
    wr(3'd2, 20);
    repeat (5) @(negedge clk);
    wr(3'd2, 0);
    watch(45, f, c, v);
    check("R11 zero count no request", c, 0);
    rd(3'd3, d); check("R11 count zero", d, 0);
  endtask

  task automatic t_mask();
    int f, c; logic [7:0] v; logic [31:0] d;
    wr(3'd0, E_ONE | E_MSK | 32'h41);
    wr(3'd2, 6);
    watch(15, f, c, v);
    check("R12 masked no pulse", c, 0);
    rd(3'd3, d); check("R12 masked countdown ran", d, 0);
    wr(3'd0, E_ONE | 32'h63);
    wr(3'd2, 3);
    watch(8, f, c, v);
    check("R12 unmasked pulse cycle", f, 3);
    check("R12 unmasked vector", v, 8'h63);
  endtask

  task automatic t_collide();
    int f, c; logic [7:0] v;
    wr(3'd0, E_ONE | 32'h41);
    wr(3'd2, 8);
    watch(6, f, c, v);
    check("R13 no early request", c, 0);
    wr(3'd2, 8);
    check("R13 load wins over expiry", {31'b0, irq_valid}, 0);
    watch(20, f, c, v);
    check("R13 expiry from new load", f, 8);
    check("R13 exactly one request", c, 1);
  endtask

  task automatic t_deadline();
    int f, c; logic [7:0] v; logic [31:0] d, t0;
    wr(3'd0, E_DL | 32'h77);
    wr(3'd4, 1);
    rd(3'd4, d); check("R9 deadline stored", d, 1);
    watch(5, f, c, v);
    check("R9 past deadline fires next cycle", f, 1);
    check("R9 single request", c, 1);
    check("R9 vector", v, 8'h77);
    rd(3'd4, d); check("R9 deadline cleared", d, 0);
    rd(3'd5, t0);
    wr(3'd4, t0 + 20);
    watch(30, f, c, v);
    check("R10 future deadline cycle", f, 19);
    check("R10 single request", c, 1);
    rd(3'd4, d); check("R10 deadline cleared", d, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_div2();
    t_periodic();
    t_switch();
    t_zero_switch();
    t_zero_init();
    t_mask();
    t_collide();
    t_deadline();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule